// File: doc/BRIEF.md
# Pipelined Complex Butterfly with Self-Rotating Twiddle

This block is the arithmetic core of one radix-2 decimation-in-time FFT stage. Each accepted item carries two complex samples, a first input `A` and a second input `C`. The block multiplies `C` by a complex twiddle factor `T` that it keeps in its own register. It then returns the sum `A + C·T` and the difference `A − C·T`. Every real and imaginary part is a signed Q1.15 value. Each product is rounded to nearest and each sum saturates.

The twiddle register is not loaded from outside. It starts at unity, and a rotate request multiplies it by a complex delta. The rotate request is an ordinary item with its first input forced to zero and the delta in the second-input slot. It passes through the same five-stage butterfly path, and its sum output goes into the twiddle register instead of to the output port. A reload request puts the register back to unity at the start of a pass. Items enter through a valid/ready handshake, and the whole pipeline stalls when the output is held.

Top module: `cplx_bfly`

## Requirements
- R1: After reset `outValid` is 0, `inReady` is 1, and the twiddle register holds unity: real part 32767 (0x7FFF) and imaginary part 0.
- R2: A butterfly item (`inOp` 2'b00, or 2'b11 which acts the same way) with first input A, second input C and twiddle X+jY produces xw = C.re·X − C.im·Y and yw = C.re·Y + C.im·X. The outputs are sumRe = A.re+xw, sumIm = A.im+yw, difRe = A.re−xw and difIm = A.im−yw.
- R3: A butterfly accepted at clock edge n shows its result with `outValid` high right after edge n+4, as long as `outReady` stays high. Results leave in the order they were accepted.
- R4: While `outValid` is 1 and `outReady` is 0, the outputs and `outValid` hold steady, `inReady` is 0, and no item is lost or duplicated.
- R5: A rotate item (`inOp` 2'b01) ignores its first input and produces no output. It replaces the twiddle with the R2 sum pair computed from a zero first input and the delta given on the second input. Every butterfly accepted after it uses the new twiddle.
- R6: A reload item (`inOp` 2'b10) sets the twiddle to unity (32767, 0) and produces no output.
- R7: A rotate or reload item is not accepted while any item is in the pipeline. A butterfly is not accepted while a rotate is in flight.
- R8: Every sum and difference, xw and yw included, saturates to the range −32768..32767.
- R9: Each product p is rounded as (p + 2^14) >> 15 with arithmetic shift, so that exact halves round toward plus infinity, and the result saturates to 16 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input item present |
| inReady | output | 1 | Item taken at this edge when inValid is also high |
| inOp | input | 2 | 00/11 butterfly, 01 rotate twiddle, 10 reload unity |
| inARe | input | 16 | First input, real part (Q1.15) |
| inAIm | input | 16 | First input, imaginary part |
| inCRe | input | 16 | Second input or delta, real part |
| inCIm | input | 16 | Second input or delta, imaginary part |
| outValid | output | 1 | Result present |
| outReady | input | 1 | Consumer takes the result |
| sumRe | output | 16 | Real part of A + C·T |
| sumIm | output | 16 | Imaginary part of A + C·T |
| difRe | output | 16 | Real part of A − C·T |
| difIm | output | 16 | Imaginary part of A − C·T |

## Verification
The first butterflies run with the unity twiddle on small mixed-sign values. This shows whether the sum and difference paths are wired the right way round and whether the two cross products are paired with the correct twiddle parts. Full-scale operands then drive the output sums past the limits, and a twiddle of one half makes the rounding land exactly on a half, which separates round-half-up from truncation and from round-half-even. A run of 45-degree rotations mixed with butterflies and a stray first input on the rotate items shows whether the twiddle is replaced, whether it is replaced only once per request, and whether the first input is really zeroed. A held-off output and rotate requests sent into a busy pipeline cover the stall and the hazard rules.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

  // number of register stages from input capture to output register
  localparam int STAGES = 5;

  typedef enum logic [1:0] {
    OP_BFLY   = 2'b00,
    OP_ROTATE = 2'b01,
    OP_UNITY  = 2'b10,
    OP_BFLY_B = 2'b11
  } bfly_op_e;

  typedef struct packed {
    logic adv;      // whole pipeline advances this cycle
    logic zeroA;    // force the first input to zero on capture
    logic twWrite;  // rotate result leaves stage 4: load twiddle
    logic twInit;   // reload twiddle with unity
  } bfly_strobe_t;

endpackage

// File: rtl/bfly_ctrl.sv
module bfly_ctrl
  import bfly_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [1:0]   inOp,
  input  logic         outReady,
  output logic         inReady,
  output logic         outValid,
  output bfly_strobe_t stb
);

  localparam int TRACK = STAGES - 1;  // stages 1..4 carry occupancy and kind

  logic [TRACK-1:0] vld;
  logic [TRACK-1:0] rot;
  logic             lastVld;
  logic             adv;
  logic             wantTw;
  logic             pipeBusy;
  logic             rotBusy;
  logic             accept;
  logic             enter;
  logic             enterRot;

  assign adv      = !lastVld || outReady;
  assign wantTw   = (inOp == OP_ROTATE) || (inOp == OP_UNITY);
  assign pipeBusy = (|vld) || lastVld;
  assign rotBusy  = |rot;
  assign inReady  = adv && (wantTw ? !pipeBusy : !rotBusy);
  assign accept   = inValid && inReady;
  assign enter    = accept && (inOp != OP_UNITY);
  assign enterRot = accept && (inOp == OP_ROTATE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vld     <= '0;
      rot     <= '0;
      lastVld <= 1'b0;
    end else if (adv) begin
      vld     <= {vld[TRACK-2:0], enter};
      rot     <= {rot[TRACK-2:0], enterRot};
      lastVld <= vld[TRACK-1] && !rot[TRACK-1];
    end
  end

  assign outValid    = lastVld;
  assign stb.adv     = adv;
  assign stb.zeroA   = (inOp == OP_ROTATE);
  assign stb.twWrite = adv && vld[TRACK-1] && rot[TRACK-1];
  assign stb.twInit  = accept && (inOp == OP_UNITY);

  // R7
  rot_into_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && wantTw) |-> (vld == '0 && !lastVld));

  // R7
  bfly_not_during_rot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && !wantTw) |-> (rot == '0));

  // R4
  stall_holds_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

  // R3
  valid_from_stage4_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(vld[TRACK-1] && !rot[TRACK-1]));

endmodule

// File: rtl/bfly_datapath.sv
module bfly_datapath
  import bfly_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  bfly_strobe_t        stb,
  input  logic signed [W-1:0] inARe,
  input  logic signed [W-1:0] inAIm,
  input  logic signed [W-1:0] inCRe,
  input  logic signed [W-1:0] inCIm,
  output logic signed [W-1:0] sumRe,
  output logic signed [W-1:0] sumIm,
  output logic signed [W-1:0] difRe,
  output logic signed [W-1:0] difIm
);

  localparam int FRAC = W - 1;
  localparam int PW   = 2 * W;
  localparam int EW   = PW + 1;
  localparam int MAXI = (1 << (W - 1)) - 1;
  localparam int MINI = -(1 << (W - 1));
  localparam int HALF = 1 << (FRAC - 1);
  localparam logic signed [W-1:0] UNITY = W'(MAXI);

  function automatic logic signed [W-1:0] clampW(input logic signed [EW-1:0] v);
    if (v > EW'(MAXI))      return W'(MAXI);
    else if (v < EW'(MINI)) return W'(MINI);
    else                    return v[W-1:0];
  endfunction

  function automatic logic signed [W-1:0] roundQ(input logic signed [PW-1:0] p);
    logic signed [EW-1:0] t;
    t = EW'(p) + EW'(HALF);
    return clampW(t >>> FRAC);
  endfunction

  function automatic logic signed [W-1:0] addSat(input logic signed [W-1:0] a,
                                                 input logic signed [W-1:0] b);
    return clampW(EW'(a) + EW'(b));
  endfunction

  function automatic logic signed [W-1:0] subSat(input logic signed [W-1:0] a,
                                                 input logic signed [W-1:0] b);
    return clampW(EW'(a) - EW'(b));
  endfunction

  // twiddle register
  logic signed [W-1:0] twRe, twIm;

  // stage 1: captured operands
  logic signed [W-1:0] s1ARe, s1AIm, s1CRe, s1CIm;
  // stage 2: raw products
  logic signed [PW-1:0] s2Pcx, s2Pdy, s2Pcy, s2Pdx;
  logic signed [W-1:0]  s2ARe, s2AIm;
  // stage 3: rounded products
  logic signed [W-1:0]  s3Rcx, s3Rdy, s3Rcy, s3Rdx;
  logic signed [W-1:0]  s3ARe, s3AIm;
  // stage 4: rotated second input
  logic signed [W-1:0]  s4Xw, s4Yw;
  logic signed [W-1:0]  s4ARe, s4AIm;
  // stage 5 inputs, also the rotate result
  logic signed [W-1:0]  nSumRe, nSumIm, nDifRe, nDifIm;

  assign nSumRe = addSat(s4ARe, s4Xw);
  assign nSumIm = addSat(s4AIm, s4Yw);
  assign nDifRe = subSat(s4ARe, s4Xw);
  assign nDifIm = subSat(s4AIm, s4Yw);

  always_ff @(posedge clk) begin
    if (stb.adv) begin
      s1ARe <= stb.zeroA ? '0 : inARe;
      s1AIm <= stb.zeroA ? '0 : inAIm;
      s1CRe <= inCRe;
      s1CIm <= inCIm;

      s2Pcx <= PW'(s1CRe) * PW'(twRe);
      s2Pdy <= PW'(s1CIm) * PW'(twIm);
      s2Pcy <= PW'(s1CRe) * PW'(twIm);
      s2Pdx <= PW'(s1CIm) * PW'(twRe);
      s2ARe <= s1ARe;
      s2AIm <= s1AIm;

      s3Rcx <= roundQ(s2Pcx);
      s3Rdy <= roundQ(s2Pdy);
      s3Rcy <= roundQ(s2Pcy);
      s3Rdx <= roundQ(s2Pdx);
      s3ARe <= s2ARe;
      s3AIm <= s2AIm;

      s4Xw  <= subSat(s3Rcx, s3Rdy);
      s4Yw  <= addSat(s3Rcy, s3Rdx);
      s4ARe <= s3ARe;
      s4AIm <= s3AIm;

      sumRe <= nSumRe;
      sumIm <= nSumIm;
      difRe <= nDifRe;
      difIm <= nDifIm;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.twInit) begin
      twRe <= UNITY;
      twIm <= '0;
    end else if (stb.twWrite) begin
      twRe <= nSumRe;
      twIm <= nSumIm;
    end
  end

  // R4
  stall_holds_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.adv |=> ($stable(sumRe) && $stable(sumIm) && $stable(difRe) && $stable(difIm)));

  // R6
  reload_unity_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.twInit |=> (twRe == UNITY && twIm == '0));

endmodule

// File: rtl/cplx_bfly.sv
module cplx_bfly
  import bfly_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  output logic                inReady,
  input  logic [1:0]          inOp,
  input  logic signed [W-1:0] inARe,
  input  logic signed [W-1:0] inAIm,
  input  logic signed [W-1:0] inCRe,
  input  logic signed [W-1:0] inCIm,
  output logic                outValid,
  input  logic                outReady,
  output logic signed [W-1:0] sumRe,
  output logic signed [W-1:0] sumIm,
  output logic signed [W-1:0] difRe,
  output logic signed [W-1:0] difIm
);

  bfly_strobe_t stb;

  bfly_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inOp     (inOp),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .stb      (stb)
  );

  bfly_datapath #(.W(W)) i_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .inARe (inARe),
    .inAIm (inAIm),
    .inCRe (inCRe),
    .inCIm (inCIm),
    .sumRe (sumRe),
    .sumIm (sumIm),
    .difRe (difRe),
    .difIm (difIm)
  );

endmodule

// File: tb/test_cplx_bfly.sv
module test_cplx_bfly;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [1:0] inOp = 2'b00;
  logic signed [15:0] inARe = '0, inAIm = '0, inCRe = '0, inCIm = '0;
  logic outValid;
  logic outReady = 1'b1;
  logic signed [15:0] sumRe, sumIm, difRe, difIm;

  always #4 clk = ~clk;  // 125 MHz

  cplx_bfly i_cplx_bfly (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inOp(inOp),
    .inARe(inARe), .inAIm(inAIm), .inCRe(inCRe), .inCIm(inCIm),
    .outValid(outValid), .outReady(outReady),
    .sumRe(sumRe), .sumIm(sumIm), .difRe(difRe), .difIm(difIm)
  );

  typedef struct {
    int sr, si, dr, di;
    int acc;
    string tag;
  } exp_t;

  exp_t sb[$];
  int nChk = 0, nFail = 0, cyc = 0;
  bit latChk = 1'b0;
  int twX = 32767, twY = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int sat16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int rnd(input int a, input int b);
    int p;
    p = a * b;
    return sat16((p + 16384) >>> 15);
  endfunction

  task automatic chk(input bit ok, input string msg, input int act, input int expv);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, expv);
    end
  endtask

  // driver: waits for acceptance, updates the model, pushes expected result
  task automatic send(input logic [1:0] op, input int ar, input int ai,
                      input int cr, input int ci, input string tag);
    int xw, yw;
    exp_t e;
    @(posedge clk); #1;
    inValid = 1'b1; inOp = op;
    inARe = 16'(ar); inAIm = 16'(ai); inCRe = 16'(cr); inCIm = 16'(ci);
    #2;
    while (!inReady) begin
      @(posedge clk); #3;
    end
    xw = sat16(rnd(cr, twX) - rnd(ci, twY));
    yw = sat16(rnd(cr, twY) + rnd(ci, twX));
    if (op == 2'b01) begin
      twX = xw; twY = yw;       // zero first input: sum equals (xw, yw)
    end else if (op == 2'b10) begin
      twX = 32767; twY = 0;
    end else begin
      e.sr = sat16(ar + xw); e.si = sat16(ai + yw);
      e.dr = sat16(ar - xw); e.di = sat16(ai - yw);
      e.acc = cyc + 1; e.tag = tag;
      sb.push_back(e);
    end
    @(posedge clk); #1;
    inValid = 1'b0;
  endtask

  // monitor: pops and compares as results are taken
  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R5 unexpected output (no item pending)", sumRe, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(sumRe == 16'(e.sr) && sumIm == 16'(e.si) && difRe == 16'(e.dr) && difIm == 16'(e.di),
            $sformatf("%s result sum=(%0d,%0d) dif=(%0d,%0d) exp sum=(%0d,%0d) dif=(%0d,%0d)",
                      e.tag, sumRe, sumIm, difRe, difIm, e.sr, e.si, e.dr, e.di),
            sumRe, e.sr);
        if (latChk) chk(cyc == e.acc + 4, {"R3 latency ", e.tag}, cyc - e.acc, 4);
      end
    end
  end

  task automatic drain();
    int n = 0;
    while (sb.size() != 0 && n < 200) begin
      @(posedge clk); n++;
    end
    repeat (6) @(posedge clk);
    chk(sb.size() == 0, "drain: pending results left", sb.size(), 0);
  endtask

  task automatic finish();
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish();
  end

  initial begin
    int held;
    repeat (4) @(posedge clk);
    #2;
    // R1: reset state
    chk(outValid == 1'b0, "R1 outValid low in reset", outValid, 0);
    @(posedge clk); #1; rstN = 1'b1;
    #2;
    chk(outValid == 1'b0, "R1 outValid low after reset", outValid, 0);
    chk(inReady == 1'b1, "R1 inReady high after reset", inReady, 1);

    // R1 R2 R3: unity twiddle, assorted patterns, latency checked
    latChk = 1'b1;
    send(2'b00, 1000, -2000, 3000, 4000, "R1_unity R2");
    send(2'b00, 0, 0, 0, 0, "R2 zeros");
    send(2'b00, -12345, 678, -300, 17, "R2 mixed");
    send(2'b11, 50, -60, 700, -800, "R2 alt opcode");
    // R8: saturating sums
    send(2'b00, 32767, -32768, 32767, -32768, "R8 saturate");
    send(2'b00, -32768, 32767, 32767, -32768, "R8 saturate dif");
    drain();

    // R9: twiddle of one half, exact half-LSB products
    send(2'b01, 0, 0, 16384, 0, "R9 rotate");
    send(2'b00, 0, 0, 1, 0, "R9 half up");      // xw=1: sum (1,0) dif (-1,0)
    send(2'b00, 0, 0, -1, 0, "R9 neg half");    // xw=0: sum (0,0)
    send(2'b00, 5, 7, 3, -3, "R9 mixed");
    drain();

    // R6: reload restores unity
    send(2'b10, 0, 0, 0, 0, "R6 reload");
    send(2'b00, 11, 22, 333, -444, "R6 after reload");
    drain();

    // R5: 45-degree rotations with a stray first input, interleaved with butterflies
    for (int k = 0; k < 8; k++) begin
      send(2'b01, 9999, -9999, 23170, 23170, "R5 rotate");
      send(2'b00, 100, -100, 20000, 0, "R5 after rotate");
      send(2'b00, 0, 0, 0, 15000, "R5 imag probe");
    end
    drain();
    latChk = 1'b0;

    // R7: rotate held while a butterfly is in flight
    send(2'b00, 1, 2, 3, 4, "R7 first");
    @(posedge clk); #1;
    inValid = 1'b1; inOp = 2'b01; inCRe = 16'sd100; inCIm = 16'sd0;
    #2;
    chk(inReady == 1'b0, "R7 rotate held while busy", inReady, 0);
    send(2'b01, 0, 0, 32767, 0, "R7 rotate");
    inValid = 1'b1; inOp = 2'b00;
    #1;
    chk(inReady == 1'b0, "R7 butterfly held during rotate", inReady, 0);
    inOp = 2'b10;
    #1;
    chk(inReady == 1'b0, "R7 reload held during rotate", inReady, 0);
    send(2'b00, 1000, 1000, 12000, -7000, "R7 after rotate");
    drain();

    // R4: back-pressure
    @(posedge clk); #1; outReady = 1'b0;
    send(2'b00, 400, 500, 6000, 7000, "R4 held A");
    send(2'b00, -400, -500, -6000, 100, "R4 held B");
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(outValid == 1'b1, "R4 valid while held", outValid, 1);
    held = sumRe;
    @(negedge clk);
    chk(sumRe == 16'(held), "R4 output stable", sumRe, held);
    chk(inReady == 1'b0, "R4 inReady low while stalled", inReady, 0);
    chk(sb.size() == 2, "R4 nothing lost while held", sb.size(), 2);
    @(posedge clk); #1; outReady = 1'b1;
    drain();

    finish();
  end

endmodule